// File: doc/BRIEF.md
# Four-Digit Decimal Stopwatch with Scanned Display

The block counts seconds on four decimal digits from a 1 kHz system clock. A free-running divider produces one count enable per second. The digits run 0 to 9 and carry into the next digit up, so the value goes from 0000 to 9999 and then wraps to 0000.

Three push-button inputs control the block: start, stop and mode. Each raw button passes through a synchroniser and a debouncer first. A three-state controller then decides whether the 1 Hz enable advances the count, or whether each start press steps the count by one.

The digits are shown on one shared seven-segment display with a decimal point. The display is scanned one digit per clock. While the count is not running in automatic mode, the display blinks. A polarity input inverts every display output, so the block can drive either common-anode or common-cathode parts.

The controller has three states:

- **ST_IDLE**: automatic mode, stopped.
  - start press goes to ST_RUN.
  - mode press goes to ST_MANUAL.
- **ST_RUN**: automatic mode, counting on the 1 Hz enable.
  - debounced stop goes to ST_IDLE.
  - mode press goes to ST_MANUAL.
- **ST_MANUAL**: manual mode.
  - each start press steps the count by one.
  - mode press goes to ST_IDLE.

A mode press takes priority over start and stop in the same cycle.

Top module: `stopwatch4`

## Requirements
- R1: A synchronous active-high reset clears the count to 0000 and leaves the controller in ST_IDLE (automatic mode, not counting).
- R2: In automatic mode, a debounced start press begins counting, and the count then rises by one every DIV clocks. A debounced stop halts the count without clearing it. A later start resumes from the held value.
- R3: Each digit holds only values 0 to 9. A digit steps when every digit below it is 9 and a step occurs. A step at 9999 gives 0000.
- R4: In manual mode the 1 Hz enable has no effect on the count. Each debounced start press (rising level) adds exactly one.
- R5: Each mode press toggles between automatic and manual mode exactly once, however long the button is held. The mode cannot toggle again until the button has been released.
- R6: A debounced button level follows the raw input only after the synchronised input has differed from the current level for DEB_LIM (20) consecutive clocks. A shorter pulse has no effect.
- R7: Exactly one digit select is active in every clock. The selection advances every clock in the order digit 0 (units), 1, 2, 3, then back to 0.
- R8: The segment outputs carry the active-high pattern of the selected digit with the decimal point off. Bit 0 is segment a and bit 6 is segment g; bit 7 is the decimal point. The patterns in hex are:

  | Digit | 0 | 1 | 2 | 3 | 4 | 5 | 6 | 7 | 8 | 9 |
  |---|---|---|---|---|---|---|---|---|---|---|
  | Pattern | 3F | 06 | 5B | 4F | 66 | 6D | 7D | 07 | 7F | 6F |

- R9: The display blanks all segments during DIV/2 of every DIV clocks while in ST_IDLE or ST_MANUAL. It is never blanked in ST_RUN.
- R10: With the polarity input high, every segment line and every digit-select line is inverted. The active digit select is then the only low line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (1 kHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| inv_i | input | 1 | Output polarity: 1 inverts all display lines |
| start_i | input | 1 | Raw start button |
| stop_i | input | 1 | Raw stop button |
| mode_i | input | 1 | Raw mode button |
| seg_o | output | 8 | Segments a..g in bits 0..6, decimal point in bit 7 |
| dig_o | output | NDIG | Digit selects, bit 0 is the units digit |

## Verification
The count is read back only through the scanned display, by decoding the segment pattern shown with each digit select. This makes the segment code, the digit order and the stored count checkable together.

Automatic counting is tried with start, stop and a resume. This separates a stop that halts the count from one that clears it.

A long held mode press followed by a single start press separates a locked toggle from a repeating one. A start pulse shorter than the debounce window separates filtered input from raw input.

An automatic run close to 9999, finished with manual steps through 9999 to 0000, exercises the full carry chain and the wrap. The blank cycles are counted over exactly one divider period in each state. The polarity input is then checked at the raw pins.

// File: rtl/sw_pkg.sv
package sw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_MANUAL = 2'd2
    } sw_state_e;

    // Active-high segment pattern: bit0 = a ... bit6 = g, bit7 = dp (off)
    function automatic logic [7:0] seg_of(input logic [3:0] v);
        logic [7:0] p;
        unique case (v)
            4'd0:    p = 8'h3F;
            4'd1:    p = 8'h06;
            4'd2:    p = 8'h5B;
            4'd3:    p = 8'h4F;
            4'd4:    p = 8'h66;
            4'd5:    p = 8'h6D;
            4'd6:    p = 8'h7D;
            4'd7:    p = 8'h07;
            4'd8:    p = 8'h7F;
            4'd9:    p = 8'h6F;
            default: p = 8'h00;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sw_debounce.sv
module sw_debounce #(
    parameter int LIM = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic level_o
);
    localparam int CW = (LIM > 1) ? $clog2(LIM) : 1;

    logic          meta_q;
    logic          sync_q;
    logic          level_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q  <= 1'b0;
            sync_q  <= 1'b0;
            level_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            meta_q <= raw_i;
            sync_q <= meta_q;
            if (sync_q == level_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(LIM - 1)) begin
                level_q <= sync_q;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign level_o = level_q;

    AST_DB_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sync_q != level_q && cnt_q != CW'(LIM - 1)) |=> $stable(level_q)); // R6

endmodule

// File: rtl/sw_digits.sv
module sw_digits #(
    parameter int NDIG = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    output logic [4*NDIG-1:0] digits_o
);
    localparam logic [4*NDIG-1:0] ALL_NINE = {NDIG{4'h9}};

    logic [NDIG:0] carry;
    logic [3:0]    dq [NDIG];

    assign carry[0] = step_i;

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        assign carry[i+1] = carry[i] & (dq[i] == 4'd9);

        always_ff @(posedge clk) begin
            if (rst) begin
                dq[i] <= 4'd0;
            end else if (carry[i]) begin
                dq[i] <= (dq[i] == 4'd9) ? 4'd0 : dq[i] + 4'd1;
            end
        end

        assign digits_o[i*4 +: 4] = dq[i];

        AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
            digits_o[i*4 +: 4] <= 4'd9); // R3
    end

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (step_i && digits_o == ALL_NINE) |=> (digits_o == '0)); // R3

endmodule

// File: rtl/sw_display.sv
module sw_display #(
    parameter int NDIG = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4*NDIG-1:0] digits_i,
    input  logic              blank_i,
    input  logic              inv_i,
    output logic [7:0]        seg_o,
    output logic [NDIG-1:0]   dig_o
);
    import sw_pkg::*;

    localparam int SW = (NDIG > 1) ? $clog2(NDIG) : 1;

    logic [SW-1:0]   sel_q;
    logic [NDIG-1:0] sel_oh;
    logic [3:0]      cur;
    logic [7:0]      seg_pos;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (sel_q == SW'(NDIG - 1)) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_q + 1'b1;
        end
    end

    always_comb begin
        sel_oh  = NDIG'(1) << sel_q;
        cur     = digits_i[sel_q*4 +: 4];
        seg_pos = blank_i ? 8'h00 : seg_of(cur);
    end

    assign seg_o = seg_pos ^ {8{inv_i}};
    assign dig_o = sel_oh ^ {NDIG{inv_i}};

    AST_ONE_DIGIT: assert property (@(posedge clk) disable iff (rst)
        $countones(dig_o ^ {NDIG{inv_i}}) == 1); // R7
    AST_BLANK_DARK: assert property (@(posedge clk) disable iff (rst)
        blank_i |-> ((seg_o ^ {8{inv_i}}) == 8'h00)); // R9

endmodule

// File: rtl/stopwatch4.sv
module stopwatch4 #(
    parameter int DIV     = 1000,
    parameter int DEB_LIM = 20,
    parameter int NDIG    = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            inv_i,
    input  logic            start_i,
    input  logic            stop_i,
    input  logic            mode_i,
    output logic [7:0]      seg_o,
    output logic [NDIG-1:0] dig_o
);
    import sw_pkg::*;

    localparam int CW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;

    logic [2:0] raw_btn;
    logic [2:0] btn_db;
    logic       start_db;
    logic       stop_db;
    logic       mode_db;

    assign raw_btn = {mode_i, stop_i, start_i};

    for (genvar b = 0; b < 3; b++) begin : g_deb
        sw_debounce #(.LIM(DEB_LIM)) u_deb (
            .clk     (clk),
            .rst     (rst),
            .raw_i   (raw_btn[b]),
            .level_o (btn_db[b])
        );
    end

    assign start_db = btn_db[0];
    assign stop_db  = btn_db[1];
    assign mode_db  = btn_db[2];

    // Free-running divider: one tick per DIV clocks, also sets blink phase
    logic [CW-1:0] div_q;
    logic          tick;

    always_ff @(posedge clk) begin
        if (rst || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = (div_q == CW'(DIV - 1));

    // Press edge and lock flags
    logic start_prev_q;
    logic mode_lock_q;
    logic start_rise;
    logic mode_tog;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_prev_q <= 1'b0;
            mode_lock_q  <= 1'b0;
        end else begin
            start_prev_q <= start_db;
            mode_lock_q  <= mode_db;
        end
    end

    assign start_rise = start_db & ~start_prev_q;
    assign mode_tog   = mode_db & ~mode_lock_q;

    // Controller
    sw_state_e state_q;
    sw_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (mode_tog)        state_d = ST_MANUAL;
                else if (start_rise) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (mode_tog)        state_d = ST_MANUAL;
                else if (stop_db)    state_d = ST_IDLE;
            end
            ST_MANUAL: begin
                if (mode_tog)        state_d = ST_IDLE;
            end
            default:                 state_d = ST_IDLE;
        endcase
    end

    logic step;
    logic blink_en;
    logic blank;

    always_comb begin
        step     = 1'b0;
        blink_en = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                step     = 1'b0;
                blink_en = 1'b1;
            end
            ST_RUN: begin
                step     = tick;
                blink_en = 1'b0;
            end
            ST_MANUAL: begin
                step     = start_rise & ~mode_tog;
                blink_en = 1'b1;
            end
            default: begin
                step     = 1'b0;
                blink_en = 1'b1;
            end
        endcase
        blank = blink_en && (div_q >= CW'(HALF));
    end

    logic [4*NDIG-1:0] digits;

    sw_digits #(.NDIG(NDIG)) u_digits (
        .clk      (clk),
        .rst      (rst),
        .step_i   (step),
        .digits_o (digits)
    );

    sw_display #(.NDIG(NDIG)) u_disp (
        .clk      (clk),
        .rst      (rst),
        .digits_i (digits),
        .blank_i  (blank),
        .inv_i    (inv_i),
        .seg_o    (seg_o),
        .dig_o    (dig_o)
    );

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |=> $stable(digits)); // R2
    AST_MANUAL_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MANUAL && !start_rise) |=> $stable(digits)); // R4
    AST_MODE_ONCE: assert property (@(posedge clk) disable iff (rst)
        mode_tog |=> !mode_tog); // R5

endmodule

// File: tb/stopwatch4_tb_top.sv
module stopwatch4_tb_top;

    localparam int DIV  = 10;
    localparam int DEB  = 20;
    localparam int NDIG = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            inv_i = 1'b0;
    logic            start_i = 1'b0;
    logic            stop_i = 1'b0;
    logic            mode_i = 1'b0;
    logic [7:0]      seg_o;
    logic [NDIG-1:0] dig_o;

    int  vectors = 0;
    int  fails   = 0;
    bit  done    = 1'b0;

    always #2 clk = ~clk;

    stopwatch4 #(.DIV(DIV), .DEB_LIM(DEB), .NDIG(NDIG)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .inv_i   (inv_i),
        .start_i (start_i),
        .stop_i  (stop_i),
        .mode_i  (mode_i),
        .seg_o   (seg_o),
        .dig_o   (dig_o)
    );

    function automatic int dec7(input logic [7:0] s);
        case (s)
            8'h3F: return 0;
            8'h06: return 1;
            8'h5B: return 2;
            8'h4F: return 3;
            8'h66: return 4;
            8'h6D: return 5;
            8'h7D: return 6;
            8'h07: return 7;
            8'h7F: return 8;
            8'h6F: return 9;
            default: return 15;
        endcase
    endfunction

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        vectors++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press(ref logic btn);
        @(negedge clk) btn = 1'b1;
        wait_cyc(40);
        btn = 1'b0;
        wait_cyc(40);
    endtask

    // Read the four digits back through the scanned display
    task automatic read_val(output int val, output bit ok);
        bit [3:0]   seen;
        int         dv [NDIG];
        logic [7:0] s;
        logic [NDIG-1:0] d;
        seen = '0;
        ok   = 1'b1;
        for (int k = 0; k < NDIG; k++) dv[k] = 0;
        for (int c = 0; c < 400 && seen != 4'hF; c++) begin
            @(negedge clk);
            s = inv_i ? ~seg_o : seg_o;
            d = inv_i ? ~dig_o : dig_o;
            if (s != 8'h00) begin
                for (int k = 0; k < NDIG; k++) begin
                    if (d[k]) begin
                        dv[k]   = dec7(s);
                        seen[k] = 1'b1;
                        if (dv[k] > 9) ok = 1'b0;
                    end
                end
            end
        end
        if (seen != 4'hF) ok = 1'b0;
        val = dv[3]*1000 + dv[2]*100 + dv[1]*10 + dv[0];
    endtask

    task automatic blank_count(output int n);
        logic [7:0] s;
        n = 0;
        for (int c = 0; c < DIV; c++) begin
            @(negedge clk);
            s = inv_i ? ~seg_o : seg_o;
            if (s == 8'h00) n++;
        end
    endtask

    task automatic do_reset;
        rst = 1'b1;
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);
    endtask

    task automatic t_reset;
        int v; bit ok; int nb;
        do_reset();
        read_val(v, ok);
        chk(ok && v == 0, "R1 reset count", v, 0);
        chk(ok, "R8 segment patterns at reset", ok, 1);
        blank_count(nb);
        chk(nb == DIV/2, "R1 R9 idle blink after reset", nb, DIV/2);
    endtask

    task automatic t_scan;
        logic [NDIG-1:0] prev;
        logic [NDIG-1:0] nxt;
        bit good;
        good = 1'b1;
        @(negedge clk) prev = dig_o;
        if ($countones(prev) != 1) good = 1'b0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            nxt = {prev[NDIG-2:0], prev[NDIG-1]};
            if (dig_o != nxt) good = 1'b0;
            prev = dig_o;
        end
        chk(good, "R7 scan order one-hot", dig_o, nxt);
    endtask

    task automatic t_auto;
        int v1; int v2; int v3; bit ok; int nb;
        press(start_i);
        wait_cyc(60);
        blank_count(nb);
        chk(nb == 0, "R9 steady while running", nb, 0);
        press(stop_i);
        read_val(v1, ok);
        chk(ok && v1 >= 10 && v1 <= 25, "R2 auto count advanced", v1, 17);
        wait_cyc(100);
        read_val(v2, ok);
        chk(ok && v2 == v1, "R2 stop holds count", v2, v1);
        press(start_i);
        wait_cyc(50);
        press(stop_i);
        read_val(v3, ok);
        chk(ok && v3 > v1 + 5, "R2 resume without clear", v3, v1 + 10);
    endtask

    task automatic t_invert;
        int v1; int v2; bit ok;
        read_val(v1, ok);
        inv_i = 1'b1;
        read_val(v2, ok);
        chk(ok && v2 == v1, "R10 inverted readback", v2, v1);
        @(negedge clk);
        chk($countones(dig_o) == NDIG-1, "R10 one low digit select", $countones(dig_o), NDIG-1);
        chk(seg_o[7] == 1'b1, "R10 R8 decimal point inverted off", seg_o[7], 1);
        inv_i = 1'b0;
        wait_cyc(2);
    endtask

    task automatic t_manual;
        int v0; int v1; int v2; int v3; bit ok; int nb;
        @(negedge clk) mode_i = 1'b1;
        wait_cyc(200);
        mode_i = 1'b0;
        wait_cyc(40);
        blank_count(nb);
        chk(nb == DIV/2, "R9 manual blink", nb, DIV/2);
        read_val(v0, ok);
        wait_cyc(100);
        read_val(v1, ok);
        chk(ok && v1 == v0, "R4 tick ignored in manual", v1, v0);
        press(start_i);
        wait_cyc(50);
        read_val(v2, ok);
        chk(ok && v2 == v0 + 1, "R4 R5 one step per press, single toggle", v2, v0 + 1);
        @(negedge clk) start_i = 1'b1;
        wait_cyc(10);
        start_i = 1'b0;
        wait_cyc(60);
        read_val(v3, ok);
        chk(ok && v3 == v2, "R6 short pulse rejected", v3, v2);
        press(mode_i);
        wait_cyc(100);
        read_val(v3, ok);
        chk(ok && v3 == v2, "R5 back to idle automatic", v3, v2);
    endtask

    task automatic t_wrap;
        int v; bit ok;
        do_reset();
        press(start_i);
        wait_cyc(99700);
        press(stop_i);
        read_val(v, ok);
        chk(ok && v >= 9900 && v <= 9999, "R3 long run below wrap", v, 9975);
        press(mode_i);
        for (int p = v; p < 9999; p++) press(start_i);
        read_val(v, ok);
        chk(ok && v == 9999, "R3 carry chain to 9999", v, 9999);
        press(start_i);
        read_val(v, ok);
        chk(ok && v == 0, "R3 wrap 9999 to 0000", v, 0);
    endtask

    initial begin
        t_reset();
        t_scan();
        t_auto();
        t_invert();
        t_manual();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule